// File: doc/BRIEF.md
# Register-Exchange Survivor Window

This block holds the decoded-bit history of every trellis state for a Viterbi decoder. Each history is a row of `DEPTH` bits, and the block updates the rows with the register-exchange method. On every cycle that carries a set of decisions from the add-compare-select stage, each state builds its new row from its chosen predecessor's row. It takes that row, shifts it by one position and places the input bit that leads into the state at the young end. One bank of 32 rows serves both a 32-state trellis and an 8-state trellis. In the 8-state case, the low eight rows take their predecessor links through a mode multiplexer.

The decoded output is combinational from the oldest column of the window. It is the majority of the oldest bits of all rows that are active in the current trellis size. A tie resolves to 1. A bit that enters the window appears in the oldest column after exactly `DEPTH` updates. Clearing happens on synchronous reset and on a packet-start strobe. A start strobe that comes with a valid decision set applies that set to the freshly cleared rows.

Top module: `rex_window`

## Requirements
- R1: In 32-state mode (`mode_large`=1), each accepted update builds row `s` (0..31) as follows. Take the row of predecessor `s>>1` when `dec[s]`=0, or of `(s>>1)+16` when `dec[s]`=1. Drop that row's oldest bit, shift it one place toward the old end, and put `s` bit 0 in the youngest position.
- R2: A bit placed in the youngest position reaches the oldest position, which drives `dout`, after exactly `DEPTH` (36) accepted updates. While fewer than 36 updates have been accepted since the last clear, `dout` is 0.
- R3: In 8-state mode (`mode_large`=0), only rows 0..7 update. Row `s` takes predecessor `s>>1` for `dec[s]`=0 and `(s>>1)+4` for `dec[s]`=1. Bits `dec[31:8]` have no effect, rows 8..31 hold their values, and they do not take part in the vote.
- R4: `dout` is 1 when at least half of the active rows (8 or 32) hold a 1 in their oldest position, and 0 otherwise. An exact tie gives 1.
- R5: Synchronous active-high `rst` clears all rows, so `dout` is 0 in the cycle after reset.
- R6: `start` clears all rows. When `valid` is high in the same cycle, the update is applied to the cleared rows.
- R7: When both `valid` and `start` are low, no row changes. With the mode unchanged, `dout` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Packet-start strobe, clears all rows |
| valid | input | 1 | Decision set on `dec` is accepted this cycle |
| mode_large | input | 1 | 1 = 32-state trellis, 0 = 8-state trellis |
| dec | input | 32 | Per-state survivor decision, bit s for new state s |
| dout | output | 1 | Majority-voted decoded bit from the oldest column |

## Verification
The assertions assume that `mode_large` stays constant between `start` strobes. They also assume that `rst` and `start` are the only means of clearing, so an update counter in the checker can tell when the oldest column may first be non-zero. The stimulus picks one mode for each packet and raises `start` at every packet boundary. It varies `valid` at random so that idle cycles fall inside packets. A directed run with all decisions set to 1 from a cleared window places the first 1 in the oldest column at exactly the 36th update.

// File: rtl/rex_pkg.sv
package rex_pkg;

    localparam int unsigned WIN_DEPTH = 36;
    localparam int unsigned ST_BIG    = 32;
    localparam int unsigned ST_SMALL  = 8;

    typedef enum logic {
        TRELLIS_8  = 1'b0,
        TRELLIS_32 = 1'b1
    } trellis_e;

    typedef struct packed {
        logic     clear;
        logic     step;
        trellis_e size;
    } rex_ctl_t;

    // predecessor of a new state for a given decision and trellis size
    function automatic int unsigned pred_of(int unsigned ns, int unsigned sel, int unsigned n);
        return (sel != 0) ? ((ns >> 1) | (n >> 1)) : (ns >> 1);
    endfunction

endpackage

// File: rtl/rex_exchange.sv
module rex_exchange
    import rex_pkg::*;
#(
    parameter int unsigned DEPTH = WIN_DEPTH,
    parameter int unsigned ROW   = 0
) (
    input  logic [DEPTH-2:0] pred0,
    input  logic [DEPTH-2:0] pred1,
    input  logic [DEPTH-1:0] self_row,
    input  logic             sel,
    input  logic             active,
    input  logic             step,
    output logic [DEPTH-1:0] row_next
);
    localparam logic FILL = 1'(ROW % 2);

    logic [DEPTH-2:0] pick;

    always_comb begin
        pick = sel ? pred1 : pred0;
        if (step && active) begin
            row_next = {pick, FILL};
        end else begin
            row_next = self_row;
        end
    end
endmodule

// File: rtl/rex_vote.sv
module rex_vote
    import rex_pkg::*;
#(
    parameter int unsigned NS_LG = ST_BIG,
    parameter int unsigned NS_SM = ST_SMALL
) (
    input  logic [NS_LG-1:0] col,
    input  trellis_e         size,
    output logic             maj
);
    localparam int unsigned CW = $clog2(NS_LG + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] thr;

    always_comb begin
        cnt = '0;
        for (int i = 0; i < int'(NS_LG); i++) begin
            if (i < int'(NS_SM) || size == TRELLIS_32) begin
                cnt = cnt + CW'(col[i]);
            end
        end
        thr = (size == TRELLIS_32) ? CW'(NS_LG / 2) : CW'(NS_SM / 2);
        maj = (cnt >= thr);
    end
endmodule

// File: rtl/rex_window.sv
module rex_window
    import rex_pkg::*;
#(
    parameter int unsigned DEPTH = WIN_DEPTH,
    parameter int unsigned NS_LG = ST_BIG,
    parameter int unsigned NS_SM = ST_SMALL
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             valid,
    input  logic             mode_large,
    input  logic [NS_LG-1:0] dec,
    output logic             dout
);
    rex_ctl_t ctl;
    logic [NS_LG-1:0][DEPTH-1:0] rows_q;
    logic [NS_LG-1:0][DEPTH-1:0] base;
    logic [NS_LG-1:0][DEPTH-1:0] rows_d;
    logic [NS_LG-1:0]            oldest;

    assign ctl.clear = start;
    assign ctl.step  = valid;
    assign ctl.size  = trellis_e'(mode_large);

    assign base = ctl.clear ? '0 : rows_q;

    for (genvar g = 0; g < int'(NS_LG); g++) begin : g_row
        localparam int unsigned P0  = pred_of(g, 0, NS_LG);
        localparam int unsigned P1L = pred_of(g, 1, NS_LG);
        localparam int unsigned P1S = pred_of(g, 1, NS_SM);

        logic [DEPTH-2:0] p0;
        logic [DEPTH-2:0] p1;
        logic             act;

        assign p0 = base[P0][DEPTH-2:0];

        if (g < int'(NS_SM)) begin : g_shared
            assign p1  = (ctl.size == TRELLIS_32) ? base[P1L][DEPTH-2:0]
                                                  : base[P1S][DEPTH-2:0];
            assign act = 1'b1;
        end else begin : g_big
            assign p1  = base[P1L][DEPTH-2:0];
            assign act = (ctl.size == TRELLIS_32);
        end

        rex_exchange #(.DEPTH(DEPTH), .ROW(g)) u_x (
            .pred0    (p0),
            .pred1    (p1),
            .self_row (base[g]),
            .sel      (dec[g]),
            .active   (act),
            .step     (ctl.step),
            .row_next (rows_d[g])
        );

        assign oldest[g] = rows_q[g][DEPTH-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rows_q <= '0;
        end else begin
            rows_q <= rows_d;
        end
    end

    rex_vote #(.NS_LG(NS_LG), .NS_SM(NS_SM)) u_vote (
        .col  (oldest),
        .size (ctl.size),
        .maj  (dout)
    );
endmodule

// File: rtl/rex_window_chk.sv
module rex_window_chk #(
    parameter int unsigned DEPTH = 36
) (
    input logic clk,
    input logic rst,
    input logic start,
    input logic valid,
    input logic mode_large,
    input logic dout
);
    localparam int unsigned FW = $clog2(DEPTH + 1);

    logic [FW-1:0] fill;
    logic          idle_q;
    logic          mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fill   <= '0;
            idle_q <= 1'b0;
            mode_q <= 1'b0;
        end else begin
            idle_q <= !valid && !start;
            mode_q <= mode_large;
            if (start) begin
                fill <= valid ? FW'(1) : '0;
            end else if (valid && fill < FW'(DEPTH)) begin
                fill <= fill + FW'(1);
            end
        end
    end

    // R5
    reset_clears_chk: assert property (@(posedge clk) rst |=> !dout);

    // R6
    start_clears_chk: assert property (@(posedge clk) disable iff (rst) start |=> !dout);

    // R2
    window_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (fill < FW'(DEPTH)) |-> !dout);

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (idle_q && mode_q == mode_large) |-> $stable(dout));

    // R4
    output_known_chk: assert property (@(posedge clk) disable iff (rst) !$isunknown(dout));
endmodule

bind rex_window rex_window_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .valid      (valid),
    .mode_large (mode_large),
    .dout       (dout)
);

// File: tb/rex_window_bench.sv
`timescale 1ns/1ps
module rex_window_bench;
    localparam int D  = 36;
    localparam int NL = 32;
    localparam int NS = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          valid = 1'b0;
    logic          mode_large = 1'b0;
    logic [NL-1:0] dec = '0;
    logic          dout;

    logic [D-1:0] mrow [NL];
    int    errors = 0;
    int    checks = 0;
    int    ties   = 0;
    string tag    = "R5";
    logic  done   = 1'b0;

    always #2 clk = ~clk;

    rex_window u_rex_window (
        .clk(clk), .rst(rst), .start(start), .valid(valid),
        .mode_large(mode_large), .dec(dec), .dout(dout)
    );

    task automatic check_out();
        int n = mode_large ? NL : NS;
        int c = 0;
        logic e;
        string lab;
        for (int i = 0; i < n; i++) c += int'(mrow[i][D-1]);
        e = (2 * c >= n);
        lab = tag;
        if (2 * c == n && c > 0) begin
            ties++;
            lab = "R4";
        end
        checks++;
        if (dout !== e) begin
            errors++;
            $display("FAIL %s: dout=%0b expected=%0b", lab, dout, e);
        end
    endtask

    task automatic expect_bit(input logic e, input string lab);
        checks++;
        if (dout !== e) begin
            errors++;
            $display("FAIL %s: dout=%0b expected=%0b", lab, dout, e);
        end
    endtask

    task automatic model_step(input logic r, input logic st, input logic v,
                              input logic md, input logic [NL-1:0] d);
        logic [D-1:0] tmp [NL];
        int n = md ? NL : NS;
        if (r || st) begin
            for (int i = 0; i < NL; i++) mrow[i] = '0;
        end
        if (!r && v) begin
            tmp = mrow;
            for (int s = 0; s < n; s++) begin
                int p = d[s] ? ((s >> 1) + n / 2) : (s >> 1);
                tmp[s] = {mrow[p][D-2:0], 1'(s % 2)};
            end
            mrow = tmp;
        end
    endtask

    task automatic cyc(input logic r, input logic st, input logic v, input logic md,
                       input logic [NL-1:0] d, input string t);
        @(negedge clk);
        check_out();
        tag = t;
        rst = r; start = st; valid = v; mode_large = md; dec = d;
        model_step(r, st, v, md, d);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < NL; i++) mrow[i] = '0;
        // R5: reset state
        cyc(1, 0, 0, 1, '0, "R5");
        cyc(1, 0, 0, 1, '0, "R5");
        cyc(0, 0, 0, 1, '0, "R5");
        expect_bit(1'b0, "R5");

        // R2: all-ones decisions from a cleared window
        cyc(0, 1, 1, 1, '1, "R2");
        for (int i = 1; i < D - 1; i++) cyc(0, 0, 1, 1, '1, "R2");
        cyc(0, 0, 0, 1, '1, "R7");
        expect_bit(1'b0, "R2");
        cyc(0, 0, 1, 1, '1, "R2");
        cyc(0, 0, 0, 1, $urandom, "R7");
        expect_bit(1'b1, "R2");

        // R7: idle cycles with changing decisions
        for (int i = 0; i < 5; i++) cyc(0, 0, 0, 1, $urandom, "R7");
        expect_bit(1'b1, "R7");

        // R6: start alone clears
        cyc(0, 1, 0, 1, '1, "R6");
        cyc(0, 0, 0, 1, '1, "R6");
        expect_bit(1'b0, "R6");

        // random packets in both trellis sizes
        for (int pk = 0; pk < 8; pk++) begin
            logic md = logic'(pk % 2);
            int len = $urandom_range(120, 260);
            cyc(0, 1, 1, md, $urandom, "R6");
            for (int i = 0; i < len; i++) begin
                logic v = ($urandom_range(0, 9) < 8);
                cyc(0, 0, v, md, $urandom, !v ? "R7" : (md ? "R1" : "R3"));
            end
        end

        // R5: reset in the middle of a filled window
        cyc(1, 0, 1, 0, $urandom, "R5");
        cyc(0, 0, 0, 0, $urandom, "R5");
        expect_bit(1'b0, "R5");

        checks++;
        if (ties == 0) begin
            errors++;
            $display("FAIL R4: tie cases seen=%0d expected>0", ties);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule